// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block sends stereo audio over a synchronous serial link with three wires: a bit clock, a word strobe and a data line. A processor writes a left and a right 16-bit sample into two transmit registers. The block sends them as 32-bit frames, left word first. Each frame takes one sample pair, and the pair is taken at the moment the frame starts. If software does not refill the registers, the same pair is sent again in every frame.

The bit clock is made in one of two ways. It can come from a programmable divider of the system clock, which gives a rate of system clock / (2 × (divider + 1)). It can also come from an external clock pin. A mode register sets the clock source and turns the word strobe on or off. It also chooses which strobe transitions set a sticky interrupt flag, and the processor uses that flag to refill the samples once per frame. A mute input silences the data line.

A small receive path shifts the data-in pin on each rising bit-clock edge. At every frame boundary it copies the received left and right words into holding registers, which the processor can read.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset the sck, ws, sdout and irq outputs are low, the receive holding registers read as zero, and the mode register is cleared, which selects the external clock and disables the strobe and all interrupts.
- R2: With mode bit 0 set, the sck output has a period of 2 × (divider + 1) system clocks. The divider is the low byte of a write to offset 0x8, and the upper byte of that write is ignored. The divider resets to 19, which gives a period of 40 system clocks.
- R3: A divider value of 0 is legal and gives a sck period of 2 system clocks.
- R4: A frame is 32 bit clocks. It carries the 16-bit left sample and then the 16-bit right sample, MSB first, and sdout changes on falling sck edges. While mode bit 2 is set, ws is low during the left word and high during the right word. While mode bit 2 is clear, ws stays low.
- R5: When no new samples are written, every frame repeats the last values written to the left (offset 0x0) and right (offset 0x4) transmit registers.
- R6: The transmit registers are copied into the shift path only at the ws falling transition that starts a frame. A write during a frame does not change that frame and first appears in the next frame.
- R7: With mode bits 2 and 3 set, irq is set on the same clock edge on which ws rises (the start of the right word) and stays set afterwards.
- R8: With mode bits 2 and 4 set, irq is set on the clock edge on which ws falls (the start of a frame), and not on ws rising.
- R9: With mode bits 2 and 5 set, irq is set on both ws transitions. While mode bit 2 is clear, irq is never set.
- R10: A write to the left transmit register at offset 0x0 clears irq one clock later, unless a set condition occurs on that same edge.
- R11: While mute_n is low, sdout is held at 0. The ws output and the bit clock are not affected.
- R12: The sdin input is sampled on each rising bit-clock edge. At each frame boundary the last 32 bits received are split into a left and a right word. Reads at offset 0x0 and 0x4 return the left and right word in bits 15:0, with bits 31:16 zero.
- R13: A read from any offset other than 0x0 and 0x4 returns 32'hFFFF_FFFF.
- R14: With mode bit 0 clear, bit timing follows the ext_sck input, after a synchronizer of up to three system clocks, and the sck output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Byte offset of the register access |
| wdata | input | 16 | Write data, low half of the register slot |
| rdata | output | 32 | Read data for the offset on addr |
| ext_sck | input | 1 | External bit clock, used when internal clocking is off |
| mute_n | input | 1 | Low forces sdout to 0 |
| sdin | input | 1 | Serial receive data |
| sck | output | 1 | Internally generated bit clock |
| ws | output | 1 | Word strobe: low for the left word, high for the right word |
| sdout | output | 1 | Serial transmit data |
| irq | output | 1 | Sticky frame interrupt |

## Verification
In internal mode, sck, ws, sdout and irq all change on the same system-clock edge as the bit-clock tick, and that tick comes every divider + 1 clocks. The bench polls these outputs on the falling system-clock edge and reacts to the sck and ws transitions it sees there, never to a fixed delay. So a frame is read bit by bit at each observed sck rise, and the irq state is judged on the poll where ws changes. A register write takes effect on the edge that ends the write cycle, and rdata is combinational from the holding registers, so reads are sampled one poll after addr is set. In external mode the synchronizer adds up to three clocks. The bench holds each ext_sck level for eight clocks and samples just before the next change, so that latency is absorbed.

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int SW      = 16,
  parameter int DIVW    = 8,
  parameter int DIV_RST = 19,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] wdata,
  output logic [2*SW-1:0] rdata,
  input  logic          ext_sck,
  input  logic          mute_n,
  input  logic          sdin,
  output logic          sck,
  output logic          ws,
  output logic          sdout,
  output logic          irq
);
  localparam int FR = 2 * SW;
  localparam int CW = $clog2(FR);
  localparam logic [AW-1:0] A_LTX  = AW'(0);
  localparam logic [AW-1:0] A_RTX  = AW'(4);
  localparam logic [AW-1:0] A_DIV  = AW'(8);
  localparam logic [AW-1:0] A_MODE = AW'(12);
  localparam logic [CW-1:0] LAST   = CW'(FR - 1);
  localparam logic [CW-1:0] MID    = CW'(SW - 1);

  logic [SW-1:0]   ltx, rtx, rx_l, rx_r;
  logic [DIVW-1:0] div, cnt;
  logic            int_en, ws_en, up_en, dn_en, all_en;
  logic            sck_q;
  logic [2:0]      xs;
  logic [CW-1:0]   bitcnt;
  logic [FR-1:0]   shreg, rx_sh;
  logic            irq_q;

  wire tick    = cnt >= div;
  wire rise_ev = int_en ? (tick & ~sck_q) : (xs[1] & ~xs[2]);
  wire fall_ev = int_en ? (tick &  sck_q) : (~xs[1] & xs[2]);
  wire ws_up   = fall_ev && bitcnt == MID;
  wire ws_dn   = fall_ev && bitcnt == LAST;
  wire irq_set = ws_en & ((ws_up & (up_en | all_en)) | (ws_dn & (dn_en | all_en)));
  wire irq_clr = wr_en && addr == A_LTX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ltx <= '0; rtx <= '0;
      div <= DIVW'(DIV_RST);
      {int_en, ws_en, up_en, dn_en, all_en} <= '0;
    end else if (wr_en) begin
      case (addr)
        A_LTX:  ltx <= wdata;
        A_RTX:  rtx <= wdata;
        A_DIV:  div <= wdata[DIVW-1:0];
        A_MODE: begin
          int_en <= wdata[0];
          ws_en  <= wdata[2];
          up_en  <= wdata[3];
          dn_en  <= wdata[4];
          all_en <= wdata[5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b0;
      xs    <= '0;
    end else begin
      xs <= {xs[1:0], ext_sck};
      if (tick) begin
        cnt   <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitcnt <= LAST;
      shreg  <= '0;
      rx_sh  <= '0;
      rx_l   <= '0;
      rx_r   <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (fall_ev) begin
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == LAST) begin
          shreg <= {ltx, rtx};
          rx_l  <= rx_sh[FR-1:SW];
          rx_r  <= rx_sh[SW-1:0];
        end else begin
          shreg <= {shreg[FR-2:0], 1'b0};
        end
      end
      if (rise_ev) rx_sh <= {rx_sh[FR-2:0], sdin};
      irq_q <= irq_set | (irq_q & ~irq_clr);
    end
  end

  assign sck   = int_en & sck_q;
  assign ws    = ws_en & bitcnt[CW-1];
  assign sdout = mute_n & shreg[FR-1];
  assign irq   = irq_q;
  assign rdata = (addr == A_LTX) ? {{SW{1'b0}}, rx_l} :
                 (addr == A_RTX) ? {{SW{1'b0}}, rx_r} : '1;

  a_r4_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bitcnt) |-> bitcnt == $past(bitcnt) + 1'b1);

  a_r12_rx_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rx_l) || !$stable(rx_r)) |-> bitcnt == '0);

  a_r7_irq_on_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !$stable(bitcnt[CW-1]));

  a_r10_irq_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(wr_en && addr == A_LTX));

  a_r9_no_irq_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(ws_en));
endmodule

// File: tb/sim_serial_audio_tx.sv
module sim_serial_audio_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_sck = 1'b0;
  logic        mute_n = 1'b1;
  logic        sdin;
  logic        sck, ws, sdout, irq;
  int          total = 0;
  int          fails = 0;

  always #4 clk = ~clk;
  assign sdin = sdout;

  serial_audio_tx u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_sck(ext_sck), .mute_n(mute_n), .sdin(sdin),
    .sck(sck), .ws(ws), .sdout(sdout), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sck_rise();
    logic p;
    do begin p = sck; @(negedge clk); end while (!(!p && sck));
  endtask

  task automatic wait_ws_fall();
    logic p;
    do begin p = ws; @(negedge clk); end while (!(p && !ws));
  endtask

  task automatic wait_ws_rise(output logic seen_irq);
    logic p;
    seen_irq = 1'b0;
    do begin p = ws; seen_irq |= irq; @(negedge clk); end while (!(!p && ws));
  endtask

  task automatic frame(input int wr_at, output logic [31:0] d, output logic [31:0] w);
    d = '0; w = '0;
    wait_ws_fall();
    for (int i = 0; i < 32; i++) begin
      wait_sck_rise();
      d = {d[30:0], sdout};
      w = {w[30:0], ws};
      if (i == wr_at) begin
        wr(4'h0, 16'h0F00);
        wr(4'h4, 16'h00F0);
      end
    end
  endtask

  task automatic period(input int exp, input string req);
    int n;
    wait_sck_rise();
    wait_sck_rise();
    n = 0;
    begin
      logic p;
      do begin p = sck; @(negedge clk); n++; end while (!(!p && sck));
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic t_reset();
    addr = 4'h0;
    @(negedge clk);
    chk(sck == 0 && ws == 0 && sdout == 0 && irq == 0, "R1 outputs", {sck, ws, sdout, irq}, 0);
    chk(rdata == 32'h0, "R1 rx left", rdata, 32'h0);
  endtask

  task automatic t_divider();
    wr(4'hC, 16'h0001);
    period(40, "R2 default divider");
    wr(4'h8, 16'hAB03);
    period(8, "R2 low byte divider");
    wr(4'h8, 16'h0000);
    period(2, "R3 divider zero");
    wr(4'h8, 16'h0003);
  endtask

  task automatic t_frames();
    logic [31:0] d, w;
    wr(4'hC, 16'h0005);
    wr(4'h0, 16'hA5C3);
    wr(4'h4, 16'h1234);
    frame(-1, d, w);
    chk(d == 32'hA5C31234, "R4 frame data", d, 32'hA5C31234);
    chk(w == 32'h0000FFFF, "R4 strobe pattern", w, 32'h0000FFFF);
    frame(-1, d, w);
    chk(d == 32'hA5C31234, "R5 repeat", d, 32'hA5C31234);
    frame(5, d, w);
    chk(d == 32'hA5C31234, "R6 mid-frame write", d, 32'hA5C31234);
    frame(-1, d, w);
    chk(d == 32'h0F0000F0, "R6 next frame", d, 32'h0F0000F0);
  endtask

  task automatic t_irq();
    logic s;
    wr(4'hC, 16'h000D);
    wait_ws_fall();
    wr(4'h0, 16'h1111);
    wait_ws_rise(s);
    chk(s == 0, "R7 no irq before rise", s, 0);
    chk(irq == 1, "R7 irq at ws rise", irq, 1);
    wait_ws_fall();
    chk(irq == 1, "R7 irq sticky", irq, 1);
    wr(4'h0, 16'h1111);
    chk(irq == 0, "R10 clear by left write", irq, 0);
    wr(4'hC, 16'h0015);
    wait_ws_fall();
    wr(4'h0, 16'h2222);
    wait_ws_rise(s);
    chk(irq == 0, "R8 no irq at rise", irq, 0);
    wait_ws_fall();
    chk(irq == 1, "R8 irq at ws fall", irq, 1);
    wr(4'hC, 16'h0025);
    wait_ws_fall();
    wr(4'h0, 16'h3333);
    wait_ws_rise(s);
    chk(irq == 1, "R9 every word rise", irq, 1);
    wr(4'h0, 16'h3333);
    wait_ws_fall();
    chk(irq == 1, "R9 every word fall", irq, 1);
    wr(4'hC, 16'h0039);
    wr(4'h0, 16'h4444);
    s = 0;
    for (int i = 0; i < 600; i++) begin
      s |= irq | ws;
      @(negedge clk);
    end
    chk(s == 0, "R9 strobe off no irq", s, 0);
  endtask

  task automatic t_mute();
    logic [31:0] d, w;
    wr(4'hC, 16'h0005);
    wr(4'h0, 16'hFFFF);
    wr(4'h4, 16'hFFFF);
    mute_n = 1'b0;
    frame(-1, d, w);
    chk(d == 32'h0, "R11 muted data", d, 32'h0);
    chk(w == 32'h0000FFFF, "R11 strobe unaffected", w, 32'h0000FFFF);
    mute_n = 1'b1;
    frame(-1, d, w);
    chk(d == 32'hFFFFFFFF, "R11 unmuted", d, 32'hFFFFFFFF);
  endtask

  task automatic t_rx();
    wr(4'h0, 16'h1357);
    wr(4'h4, 16'h9BDF);
    wait_ws_fall();
    wait_ws_fall();
    wait_ws_fall();
    addr = 4'h0;
    @(negedge clk);
    chk(rdata == 32'h00001357, "R12 rx left", rdata, 32'h00001357);
    addr = 4'h4;
    @(negedge clk);
    chk(rdata == 32'h00009BDF, "R12 rx right", rdata, 32'h00009BDF);
  endtask

  task automatic t_unmapped();
    logic [3:0] offs [4] = '{4'h8, 4'hC, 4'h2, 4'h1};
    for (int i = 0; i < 4; i++) begin
      addr = offs[i];
      @(negedge clk);
      chk(rdata == 32'hFFFFFFFF, "R13 unmapped read", rdata, 32'hFFFFFFFF);
    end
  endtask

  task automatic t_external();
    logic sd [80];
    logic sw [80];
    logic [31:0] d;
    logic sck_seen;
    int st;
    wr(4'h0, 16'hC0DE);
    wr(4'h4, 16'h0F0F);
    wr(4'hC, 16'h0004);
    sck_seen = 0;
    for (int i = 0; i < 80; i++) begin
      ext_sck = 1'b0;
      repeat (8) begin @(negedge clk); sck_seen |= sck; end
      sd[i] = sdout;
      sw[i] = ws;
      ext_sck = 1'b1;
      repeat (8) begin @(negedge clk); sck_seen |= sck; end
    end
    chk(sck_seen == 0, "R14 sck low in external mode", sck_seen, 0);
    st = -1;
    for (int i = 1; i < 48; i++)
      if (st < 0 && sw[i-1] && !sw[i]) st = i;
    d = '0;
    if (st > 0)
      for (int i = 0; i < 32; i++) d = {d[30:0], sd[st+i]};
    chk(st > 0 && d == 32'hC0DE0F0F, "R14 external frame", d, 32'hC0DE0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divider();
    t_frames();
    t_irq();
    t_mute();
    t_rx();
    t_unmapped();
    t_external();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule